// File: doc/BRIEF.md
# Cascadable Serial-Load Channel Driver Register

This block collects a serial bit stream into a 16-stage shift chain and presents it on a 16-wide channel-on vector through a level-sensitive output latch. One bit moves in on every rising clock edge. The newest bit sits at channel 0, and the oldest bit sits at channel 15. The oldest stage also drives a serial output, so several devices can be chained into one long string.

A latch-control input chooses between two latch modes. While it is high, the latch is transparent and the channels follow the shift chain at once, with no clock delay. While it is low, the latch keeps the channels fixed, and shifting can go on underneath. An active-low output enable gates the final stage. When the enable is low, a latched 1 turns its channel on. When the enable is high, every channel is forced off, and the shift chain keeps running.

Top module: `shift_latch_drv`

## Requirements
- R1: Each rising clock edge with reset low moves the chain one stage. The serial input enters stage 0, which maps to channel 0, and each stage k takes the old value of stage k-1.
- R2: The serial output equals stage 15, which is the bit that entered 15 clocks before the most recent one.
- R3: While the latch control is 1, the latched value equals the shift chain within the same cycle, with no clock delay.
- R4: While the latch control is 0, the latched value holds, even while the clock keeps shifting the chain.
- R5: While the enable is 0, channel k is on (1) when latched bit k is 1, and off (0) when it is 0.
- R6: While the enable is 1, all channels read 0, and the chain and the serial output keep shifting.
- R7: A high synchronous reset clears the chain at the next rising edge and clears the latch at once, so all channels and the serial output read 0.
- R8: When two devices are chained (the first device's serial output feeds the second's serial input) and 32 bits are shifted, the second device holds the first 16 bits and the first device holds the last 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi_i | input | 1 | Serial data in |
| latch_i | input | 1 | 1 = latch transparent, 0 = latch holds |
| oe_n_i | input | 1 | Output enable, active low |
| chan_on_o | output | NUM_CH | Channel on vector, 1 = on |
| sdo_o | output | 1 | Serial data out, from the oldest stage |

## Verification
A corrupted chain stage first shows on the channels in the same cycle if the latch is transparent. It also shows on the serial output after the remaining stages to the end of the chain have clocked it out, which takes at most 15 clocks. A latch that fails to hold shows as channel movement during a cycle in which the latch control is low. A blanking fault shows as any nonzero channel while the enable is high. The bench compares every channel and the serial output against its reference twice per clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  parameter int unsigned DEF_CH = 16;
  typedef enum logic {LATCH_HOLD = 1'b0, LATCH_PASS = 1'b1} latch_mode_e;
endpackage

// File: rtl/shreg_chain.sv
module shreg_chain #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi_i,
  output logic [N-1:0] chain_o,
  output logic         sdo_o
);
  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[N-2:0], sdi_i};
  end

  assign chain_o = chain_q;
  assign sdo_o   = chain_q[N-1];
endmodule

// File: rtl/level_latch.sv
module level_latch
  import shreg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         rst,
  input  latch_mode_e  mode_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] lat_q;

  always_latch begin
    if (rst)                      lat_q = '0;
    else if (mode_i == LATCH_PASS) lat_q = d_i;
  end

  assign q_o = lat_q;
endmodule

// File: rtl/chan_gate.sv
module chan_gate #(
  parameter int unsigned N = 16
) (
  input  logic         oe_n_i,
  input  logic [N-1:0] lat_i,
  output logic [N-1:0] chan_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    assign chan_o[g] = lat_i[g] & ~oe_n_i;
  end
endmodule

// File: rtl/shift_latch_drv.sv
module shift_latch_drv
  import shreg_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi_i,
  input  logic              latch_i,
  input  logic              oe_n_i,
  output logic [NUM_CH-1:0] chan_on_o,
  output logic              sdo_o
);
  logic [NUM_CH-1:0] chain;
  logic [NUM_CH-1:0] lat;
  latch_mode_e       mode;

  assign mode = latch_i ? LATCH_PASS : LATCH_HOLD;

  shreg_chain #(.N(NUM_CH)) u_chain (
    .clk(clk), .rst(rst), .sdi_i(sdi_i), .chain_o(chain), .sdo_o(sdo_o)
  );

  level_latch #(.N(NUM_CH)) u_latch (
    .rst(rst), .mode_i(mode), .d_i(chain), .q_o(lat)
  );

  chan_gate #(.N(NUM_CH)) u_gate (
    .oe_n_i(oe_n_i), .lat_i(lat), .chan_o(chan_on_o)
  );

  // R6
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> (chan_on_o == '0));

  // R3
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !oe_n_i) |-> (chan_on_o == chain));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_i && !$past(latch_i) && !oe_n_i && !$past(oe_n_i) && !$past(rst))
      |-> $stable(chan_on_o));

  // R7
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (chan_on_o == '0 && sdo_o == 1'b0));

  // R2
  sdo_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !oe_n_i) |-> (sdo_o == chan_on_o[NUM_CH-1]));
endmodule

// File: tb/shift_latch_drv_bench.sv
module shift_latch_drv_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1, sdi = 1'b0, le = 1'b0, oe_n = 1'b1;
  logic [N-1:0] chan_a, chan_b;
  logic sdo_a, sdo_b;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference state: per-device bit lists, index 0 newest
  bit ref_a[N], ref_b[N], lat_a[N], lat_b[N];

  always #2 clk = ~clk;

  shift_latch_drv #(.NUM_CH(N)) u_shift_latch_drv (
    .clk(clk), .rst(rst), .sdi_i(sdi), .latch_i(le), .oe_n_i(oe_n),
    .chan_on_o(chan_a), .sdo_o(sdo_a));

  shift_latch_drv #(.NUM_CH(N)) u_shift_latch_drv_b (
    .clk(clk), .rst(rst), .sdi_i(sdo_a), .latch_i(le), .oe_n_i(oe_n),
    .chan_on_o(chan_b), .sdo_o(sdo_b));

  task automatic upd_latch();
    for (int k = 0; k < N; k++) begin
      if (rst) begin lat_a[k] = 0; lat_b[k] = 0; end
      else if (le) begin lat_a[k] = ref_a[k]; lat_b[k] = ref_b[k]; end
    end
  endtask

  task automatic do_shift();
    bit carry;
    carry = ref_a[N-1];
    for (int k = N-1; k > 0; k--) begin
      ref_a[k] = rst ? 0 : ref_a[k-1];
      ref_b[k] = rst ? 0 : ref_b[k-1];
    end
    ref_b[0] = rst ? 0 : carry;
    ref_a[0] = rst ? 0 : sdi;
  endtask

  function automatic logic [N-1:0] exp_chan(input bit a);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = oe_n ? 1'b0 : (a ? lat_a[k] : lat_b[k]);
    return v;
  endfunction

  task automatic compare(input string tag);
    logic [N-1:0] ea, eb;
    ea = exp_chan(1); eb = exp_chan(0);
    compared++;
    if (chan_a !== ea || sdo_a !== ref_a[N-1] || chan_b !== eb || sdo_b !== ref_b[N-1]) begin
      mismatched++;
      $display("FAIL %s: chan_a=%h sdo_a=%b chan_b=%h sdo_b=%b exp %h %b %h %b",
               tag, chan_a, sdo_a, chan_b, sdo_b, ea, ref_a[N-1], eb, ref_b[N-1]);
    end
  endtask

  task automatic step(input bit d, input bit l, input bit e, input bit r, input string tag);
    @(negedge clk);
    sdi = d; le = l; oe_n = e; rst = r;
    upd_latch();
    #1 compare(tag);
    @(posedge clk);
    do_shift();
    upd_latch();
    #1 compare(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    // R7 reset state, latch transparent during reset
    step(1, 1, 0, 1, "R7 reset");
    step(1, 1, 0, 1, "R7 reset");
    // R1 R3 R5 transparent shifting, pattern 1011...
    for (int i = 0; i < 20; i++) step(((i % 4) != 1), 1, 0, 0, "R1 R3 R5 shift");
    // R2 walking one to the serial output
    step(1, 1, 0, 0, "R2 walk");
    for (int i = 0; i < 17; i++) step(0, 1, 0, 0, "R2 walk");
    // R4 hold while shifting alternating bits
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, "R4 load");
    for (int i = 0; i < 12; i++) step(i[0], 0, 0, 0, "R4 hold");
    step(0, 1, 0, 0, "R3 release");
    // R6 blanking while shifting continues
    for (int i = 0; i < 10; i++) step(1, 1, 1, 0, "R6 blank");
    step(1, 1, 0, 0, "R6 unblank");
    // R7 reset mid-run
    step(0, 0, 0, 1, "R7 midreset");
    step(1, 0, 0, 0, "R7 after");
    // R8 cascade: 32 bits, latch held, then transfer
    for (int i = 0; i < 32; i++) step(((i * 7) % 5) < 2, 0, 0, 0, "R8 cascade");
    step(0, 1, 0, 0, "R8 transfer");
    step(0, 0, 0, 0, "R8 hold");
    summary();
  end
endmodule